// File: doc/BRIEF.md
# Gate Drive Turn-On Sequencer

This block is the digital control core of a gate driver for a power switch. It takes a turn-on/turn-off command in one of three selectable forms: a plain level, an inverted level, or a pair of pulse lines in which a pulse on one line switches on and a pulse on the other switches off. Each command line first passes a glitch filter. A change on a line is accepted only after the line has held its new value for a set number of consecutive clock samples.

Once the command is accepted, the switch is not driven at once. A programmable dead time passes first, with the gate still held low. This avoids shoot-through in a half bridge. A programmable clamp interval follows, in which the gate is enabled but flagged as clamped, so that the analog stage limits the gate voltage. Full drive comes last. A turn-off command at any step returns the block to the off state. In that state the pull-down output is active. Counters stand in for the analog timing networks.

Top module: `gts_turnon_seq`

## Requirements
- R1: While reset is active, and right after it, the block is off: `pull_dn`=1, `gate_en`=0, `clamp_act`=0.
- R2: `gate_en` and `pull_dn` are always complementary, so exactly one of them is 1 in every cycle.
- R3: A command line's accepted level changes only after the line has been sampled at the new value on FILT_LEN consecutive rising edges. A pulse seen on FILT_LEN-1 edges has no effect on the outputs.
- R4: With `mode_sel`=2'b00 (direct), an accepted high on `cmd_p` requests turn-on and an accepted low requests turn-off. `cmd_n` is ignored.
- R5: With `mode_sel`=2'b01 (inverted), an accepted low on `cmd_p` requests turn-on and an accepted high requests turn-off.
- R6: With `mode_sel`=2'b10 (pulse), an accepted high on `cmd_p` with `cmd_n` low requests turn-on. An accepted high on `cmd_n` with `cmd_p` low requests turn-off. With both lines low or both high, the last request holds.
- R7: With `mode_sel`=2'b11, turn-off is requested unconditionally, and `gate_en` is 0 from the next rising edge.
- R8: A turn-on that is first sampled at edge 1 raises `gate_en` at edge FILT_LEN+`dead_cnt`+1, with the gate held off before that.
- R9: With `dead_cnt`=0, `gate_en` rises at edge FILT_LEN+1, which is one cycle after the command is accepted.
- R10: After the dead time, `clamp_act` is 1 (with `gate_en` 1) for exactly `clamp_len` cycles, and then 0 while full drive continues. `clamp_len`=0 skips the clamp interval.
- R11: A turn-off command first sampled at edge 1 gives `gate_en`=0, `clamp_act`=0 and `pull_dn`=1 from edge FILT_LEN+1, whether it arrives in the dead-time, clamp or full-drive step. An aborted dead time never enables the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_p | input | 1 | Command level (level modes) or turn-on pulse line (pulse mode) |
| cmd_n | input | 1 | Turn-off pulse line (pulse mode only) |
| mode_sel | input | 2 | 00 direct, 01 inverted, 10 pulse, 11 forced off |
| dead_cnt | input | CNT_W | Dead-time length in cycles |
| clamp_len | input | CNT_W | Clamp interval length in cycles |
| gate_en | output | 1 | Gate drive enable |
| clamp_act | output | 1 | Gate voltage clamp request |
| pull_dn | output | 1 | Gate pull-down to the negative rail |

## Verification
The sequence is run in direct mode with a nonzero dead time and clamp, and again with both set to zero. The first run measures the exact rise edge and the clamp length. The second separates a skipped step from a one-cycle step. Glitches one sample shorter than the filter length are applied to `cmd_p` and `cmd_n` in the on state and must leave the outputs unchanged. Genuine commands are then timed to the edge. Turn-off is tried within the dead time, within the clamp interval and in full drive, which tests abort handling at each step. Inverted and pulse modes are run with both-lines-high and lines-idle patterns to show that the held request survives. The forced-off mode is entered from full drive.

// File: rtl/gts_pkg.sv
package gts_pkg;
   typedef enum logic [1:0] {
      PH_OFF   = 2'd0,
      PH_DEAD  = 2'd1,
      PH_CLAMP = 2'd2,
      PH_FULL  = 2'd3
   } phase_e;

   typedef enum logic [1:0] {
      MD_DIRECT    = 2'd0,
      MD_INVERT    = 2'd1,
      MD_PULSE     = 2'd2,
      MD_FORCE_OFF = 2'd3
   } mode_e;
endpackage

// File: rtl/gts_glitch_filter.sv
module gts_glitch_filter #(
   parameter int FILT_LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic lvl_o
);
   localparam int FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

   if (FILT_LEN < 1) begin : g_bad_len
      $fatal(1, "gts_glitch_filter: FILT_LEN must be at least 1");
   end

   if (FILT_LEN == 1) begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_o <= 1'b0;
         else        lvl_o <= raw_i;
      end
   end else begin : g_count
      logic [FW-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lvl_o <= 1'b0;
            run_q <= '0;
         end else if (raw_i == lvl_o) begin
            run_q <= '0;
         end else if (run_q == FW'(FILT_LEN - 1)) begin
            lvl_o <= raw_i;
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/gts_cmd_decode.sv
module gts_cmd_decode
   import gts_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  mode_e mode_i,
   input  logic  lvl_p,
   input  logic  lvl_n,
   output logic  on_req
);
   logic hold_q;

   always_comb begin
      unique case (mode_i)
         MD_DIRECT: on_req = lvl_p;
         MD_INVERT: on_req = !lvl_p;
         MD_PULSE: begin
            if (lvl_p && !lvl_n)      on_req = 1'b1;
            else if (lvl_n && !lvl_p) on_req = 1'b0;
            else                      on_req = hold_q;
         end
         default:   on_req = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= on_req;
   end
endmodule

// File: rtl/gts_phase_fsm.sv
module gts_phase_fsm
   import gts_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             on_req,
   input  logic [CNT_W-1:0] dead_cnt,
   input  logic [CNT_W-1:0] clamp_len,
   output logic             gate_en,
   output logic             clamp_act,
   output logic             pull_dn
);
   if (CNT_W < 1) begin : g_bad_w
      $fatal(1, "gts_phase_fsm: CNT_W must be at least 1");
   end

   phase_e           ph_q, ph_d;
   logic [CNT_W-1:0] left_q, left_d;

   always_comb begin
      ph_d   = ph_q;
      left_d = left_q;
      if (!on_req) begin
         ph_d   = PH_OFF;
         left_d = '0;
      end else begin
         unique case (ph_q)
            PH_OFF: begin
               if (dead_cnt != '0) begin
                  ph_d   = PH_DEAD;
                  left_d = dead_cnt - 1'b1;
               end else if (clamp_len != '0) begin
                  ph_d   = PH_CLAMP;
                  left_d = clamp_len - 1'b1;
               end else begin
                  ph_d = PH_FULL;
               end
            end
            PH_DEAD: begin
               if (left_q != '0) begin
                  left_d = left_q - 1'b1;
               end else if (clamp_len != '0) begin
                  ph_d   = PH_CLAMP;
                  left_d = clamp_len - 1'b1;
               end else begin
                  ph_d = PH_FULL;
               end
            end
            PH_CLAMP: begin
               if (left_q != '0) left_d = left_q - 1'b1;
               else              ph_d   = PH_FULL;
            end
            default: ph_d = PH_FULL;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_OFF;
         left_q <= '0;
      end else begin
         ph_q   <= ph_d;
         left_q <= left_d;
      end
   end

   assign gate_en   = (ph_q == PH_CLAMP) || (ph_q == PH_FULL);
   assign clamp_act = (ph_q == PH_CLAMP);
   assign pull_dn   = !gate_en;
endmodule

// File: rtl/gts_turnon_seq.sv
module gts_turnon_seq
   import gts_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int FILT_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_p,
   input  logic             cmd_n,
   input  logic [1:0]       mode_sel,
   input  logic [CNT_W-1:0] dead_cnt,
   input  logic [CNT_W-1:0] clamp_len,
   output logic             gate_en,
   output logic             clamp_act,
   output logic             pull_dn
);
   localparam int NLINES = 2;

   logic [NLINES-1:0] raw_lines;
   logic [NLINES-1:0] filt_lvl;
   logic              on_req;

   assign raw_lines = {cmd_n, cmd_p};

   for (genvar li = 0; li < NLINES; li++) begin : g_line
      gts_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
         .clk   (clk),
         .rst_n (rst_n),
         .raw_i (raw_lines[li]),
         .lvl_o (filt_lvl[li])
      );
   end

   gts_cmd_decode u_dec (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode_i (mode_e'(mode_sel)),
      .lvl_p  (filt_lvl[0]),
      .lvl_n  (filt_lvl[1]),
      .on_req (on_req)
   );

   gts_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .on_req    (on_req),
      .dead_cnt  (dead_cnt),
      .clamp_len (clamp_len),
      .gate_en   (gate_en),
      .clamp_act (clamp_act),
      .pull_dn   (pull_dn)
   );
endmodule

// File: rtl/gts_turnon_seq_chk.sv
module gts_turnon_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       gate_en,
   input logic       clamp_act,
   input logic       pull_dn,
   input logic [1:0] mode_sel,
   input logic       on_req,
   input logic       lvl_p,
   input logic       raw_p
);
   AST_RESET_OFF: assert property (@(posedge clk) !rst_n |-> (pull_dn && !gate_en && !clamp_act)); // R1
   AST_GATE_PD_EXCL: assert property (@(posedge clk) disable iff (!rst_n) (gate_en != pull_dn)); // R2
   AST_FILTER_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) (lvl_p != $past(lvl_p)) |-> (lvl_p == $past(raw_p))); // R3
   AST_FORCE_OFF: assert property (@(posedge clk) disable iff (!rst_n) (mode_sel == 2'b11) |=> !gate_en); // R7
   AST_CLAMP_NEEDS_GATE: assert property (@(posedge clk) disable iff (!rst_n) clamp_act |-> gate_en); // R10
   AST_ABORT_NEXT: assert property (@(posedge clk) disable iff (!rst_n) !on_req |=> (!gate_en && !clamp_act && pull_dn)); // R11
endmodule

bind gts_turnon_seq gts_turnon_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .gate_en   (gate_en),
   .clamp_act (clamp_act),
   .pull_dn   (pull_dn),
   .mode_sel  (mode_sel),
   .on_req    (on_req),
   .lvl_p     (filt_lvl[0]),
   .raw_p     (cmd_p)
);

// File: tb/gts_turnon_seq_tb.sv
module gts_turnon_seq_tb_top;
   localparam int FILT = 4;
   localparam int CW   = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_p = 1'b0;
   logic          cmd_n = 1'b0;
   logic [1:0]    mode_sel = 2'b00;
   logic [CW-1:0] dead_cnt = '0;
   logic [CW-1:0] clamp_len = '0;
   logic          gate_en, clamp_act, pull_dn;

   int    errors = 0;
   int    checks = 0;
   int    cyc = 0;
   string cur_req = "R1";

   always #10 clk = ~clk;

   gts_turnon_seq #(.CNT_W(CW), .FILT_LEN(FILT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_p(cmd_p), .cmd_n(cmd_n),
      .mode_sel(mode_sel), .dead_cnt(dead_cnt), .clamp_len(clamp_len),
      .gate_en(gate_en), .clamp_act(clamp_act), .pull_dn(pull_dn)
   );

   task automatic chk(string req, int act, int exp, string what);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Behavioural reference model
   bit p_hist[$];
   bit n_hist[$];
   bit m_lp, m_ln, m_hold;
   int m_phase, m_rem;

   function automatic bit all_equal(bit q[$], bit v);
      if (q.size() < FILT) return 1'b0;
      foreach (q[i]) if (q[i] != v) return 1'b0;
      return 1'b1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         p_hist.delete(); n_hist.delete();
         m_lp = 0; m_ln = 0; m_hold = 0; m_phase = 0; m_rem = 0;
      end else begin
         bit want;
         case (mode_sel)
            2'b00: want = m_lp;
            2'b01: want = !m_lp;
            2'b10: want = (m_lp && !m_ln) ? 1'b1 : ((m_ln && !m_lp) ? 1'b0 : m_hold);
            default: want = 1'b0;
         endcase
         if (!want) m_phase = 0;
         else if (m_phase == 0) begin
            if (dead_cnt != 0) begin m_phase = 1; m_rem = int'(dead_cnt); end
            else if (clamp_len != 0) begin m_phase = 2; m_rem = int'(clamp_len); end
            else m_phase = 3;
         end else if (m_phase == 1) begin
            m_rem--;
            if (m_rem == 0) begin
               if (clamp_len != 0) begin m_phase = 2; m_rem = int'(clamp_len); end
               else m_phase = 3;
            end
         end else if (m_phase == 2) begin
            m_rem--;
            if (m_rem == 0) m_phase = 3;
         end
         m_hold = want;
         p_hist.push_back(cmd_p); n_hist.push_back(cmd_n);
         if (p_hist.size() > FILT) void'(p_hist.pop_front());
         if (n_hist.size() > FILT) void'(n_hist.pop_front());
         if (all_equal(p_hist, !m_lp)) m_lp = !m_lp;
         if (all_equal(n_hist, !m_ln)) m_ln = !m_ln;
      end
   end

   always @(negedge clk) begin
      chk(cur_req, int'(gate_en), (m_phase >= 2) ? 1 : 0, "gate_en vs model");
      chk(cur_req, int'(clamp_act), (m_phase == 2) ? 1 : 0, "clamp_act vs model");
      chk("R2", int'(gate_en ^ pull_dn), 1, "gate_en/pull_dn complementary");
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic edges_until(bit want_gate, output int c);
      c = 0;
      while (gate_en != want_gate && c < 300) begin @(negedge clk); c++; end
   endtask

   task automatic clamp_run(output int c);
      c = 0;
      while (clamp_act && c < 300) begin @(negedge clk); c++; end
   endtask

   initial begin
      int c;
      cur_req = "R1";
      cycles(3);
      chk("R1", int'(pull_dn), 1, "pull_dn in reset");
      chk("R1", int'(gate_en), 0, "gate_en in reset");
      rst_n = 1'b1;
      cycles(2);
      chk("R1", int'(pull_dn), 1, "pull_dn after reset");

      // direct mode, dead 5, clamp 3
      cur_req = "R8"; dead_cnt = 8'd5; clamp_len = 8'd3;
      cmd_p = 1'b1;
      edges_until(1'b1, c);
      chk("R8", c, FILT + 5 + 1, "turn-on edge with dead time");
      cur_req = "R10";
      clamp_run(c);
      chk("R10", c, 3, "clamp interval length");
      chk("R10", int'(gate_en), 1, "full drive after clamp");
      cycles(5);

      // glitch on cmd_p one sample short
      cur_req = "R3";
      cmd_p = 1'b0; cycles(FILT - 1); cmd_p = 1'b1;
      cycles(FILT + 3);
      chk("R3", int'(gate_en), 1, "short low glitch ignored");
      cur_req = "R4";
      cmd_n = 1'b1; cycles(FILT + 3); cmd_n = 1'b0;
      chk("R4", int'(gate_en), 1, "cmd_n ignored in direct mode");
      cmd_p = 1'b0;
      edges_until(1'b0, c);
      chk("R4", c, FILT + 1, "direct turn-off latency");
      cycles(4);

      // zero dead time and clamp
      cur_req = "R9"; dead_cnt = 8'd0; clamp_len = 8'd0;
      cmd_p = 1'b1;
      edges_until(1'b1, c);
      chk("R9", c, FILT + 1, "turn-on edge with zero dead time");
      chk("R10", int'(clamp_act), 0, "zero clamp skips clamp");
      cycles(3);
      chk("R10", int'(clamp_act), 0, "clamp stays off");

      // forced-off mode from full drive
      cur_req = "R7";
      mode_sel = 2'b11;
      edges_until(1'b0, c);
      chk("R7", c, 1, "forced off next edge");
      cycles(FILT + 3);

      // inverted mode (cmd_p already high)
      cur_req = "R5"; dead_cnt = 8'd2; clamp_len = 8'd4;
      mode_sel = 2'b01;
      cycles(3);
      chk("R5", int'(gate_en), 0, "inverted: high means off");
      cmd_p = 1'b0;
      edges_until(1'b1, c);
      chk("R5", c, FILT + 2 + 1, "inverted turn-on edge");
      clamp_run(c);
      chk("R10", c, 4, "clamp length in inverted mode");
      cmd_p = 1'b1;
      edges_until(1'b0, c);
      chk("R5", c, FILT + 1, "inverted turn-off latency");
      cycles(4);

      // abort during dead time, direct mode
      cur_req = "R11"; mode_sel = 2'b00; dead_cnt = 8'd20; clamp_len = 8'd10;
      cycles(FILT + 2);
      cmd_p = 1'b1; cycles(FILT + 6);
      cmd_p = 1'b0;
      begin
         int seen = 0;
         repeat (40) begin @(negedge clk); if (gate_en) seen = 1; end
         chk("R11", seen, 0, "aborted dead time never enables gate");
      end
      chk("R11", int'(pull_dn), 1, "pull_dn after dead-time abort");

      // abort during clamp
      cmd_p = 1'b1; cycles(FILT + 1 + 20 + 3);
      chk("R11", int'(clamp_act), 1, "in clamp before abort");
      cmd_p = 1'b0;
      edges_until(1'b0, c);
      chk("R11", c, FILT + 1, "abort from clamp latency");
      chk("R11", int'(clamp_act), 0, "clamp cleared by abort");
      cycles(4);

      // pulse mode
      cur_req = "R6"; mode_sel = 2'b10; dead_cnt = 8'd3; clamp_len = 8'd2;
      cycles(FILT + 2);
      chk("R6", int'(gate_en), 0, "pulse mode idle holds off");
      cmd_p = 1'b1; cycles(FILT); cmd_p = 1'b0;
      edges_until(1'b1, c);
      chk("R6", c + FILT, FILT + 3 + 1, "pulse turn-on edge");
      cycles(20);
      chk("R6", int'(gate_en), 1, "on state holds after pulse");
      cmd_p = 1'b1; cmd_n = 1'b1; cycles(FILT + 3); cmd_p = 1'b0; cmd_n = 1'b0;
      cycles(FILT + 3);
      chk("R6", int'(gate_en), 1, "both lines high is no command");
      cur_req = "R3";
      cmd_n = 1'b1; cycles(FILT - 1); cmd_n = 1'b0;
      cycles(FILT + 3);
      chk("R3", int'(gate_en), 1, "short off pulse ignored");
      cur_req = "R6";
      cmd_n = 1'b1;
      edges_until(1'b0, c);
      chk("R6", c, FILT + 1, "off pulse latency");
      cmd_n = 1'b0;
      cycles(20);
      chk("R6", int'(pull_dn), 1, "off state holds after pulse");

      cycles(5);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule